// File: doc/BRIEF.md
# Staged Seconds Timekeeper

This block keeps always-on time in seconds. It holds a 32-bit base and a 32-bit running counter, and the current time is their sum modulo 2^32. The counter advances on a one-second tick input. Software never changes the base or the counter directly. It stages a 32-bit value as two 16-bit halves and sets select bits in a control word. The operation is carried out only when an external isolation strobe rises. Reads use the same commit path: the strobe copies the selected value into two 16-bit read-back halves.

Two 32-bit software flag words sit on the same commit path. Software uses word 0 as a "time valid" marker. To set the time it writes the base, clears the counter and then writes 1 to word 0. Any other value read back from word 0 means the time is not valid. The counter has its own read path. A strobe with the counter-capture select set copies the counter into a holding register. A separate trigger write then moves the held value into a snapshot pair. The two halves of the snapshot are therefore always taken from the same counter value.

Top module: `rtc_stage_top`

## Requirements
- R1: Output `wallTime` always equals base plus counter modulo 2^32.
- R2: The counter adds one on every cycle with `secTick` high, wraps modulo 2^32, and otherwise holds its value unless it is being cleared.
- R3: A commit with main-control bit 3 set clears the counter to zero. The clear wins over a tick in the same cycle.
- R4: Address 2 holds the staged low half and address 3 the staged high half. A commit with main-control (address 0) bit 1 set loads the staged word into the base. A strobe without that bit, or that bit without a strobe, leaves the base unchanged.
- R5: A commit with main-control bit 5 loads the staged word into software word 0, and bit 6 loads it into software word 1. The time-setting sequence (base write, counter clear, word 0 = 1) reads back 1 from word 0.
- R6: A commit with main-control bit 2, 7 or 8 copies the base, word 0 or word 1 into read-back halves at addresses 4 (low) and 5 (high). When several of these bits are set, bit 2 is served first, then bit 7, then bit 8. Writes in the same commit are applied before the read, so the read returns the new value.
- R7: A commit with aux-control (address 1) bit 0 set captures the counter into a holding register. A write to address 6 with data bit 0 set copies the held value into the snapshot halves at addresses 7 (low) and 8 (high). The snapshot does not change at any other time.
- R8: A commit happens once, in the first cycle the strobe is seen high. A strobe held high for several cycles does not commit again.
- R9: After power-on reset, every register at addresses 0 to 8 reads zero and `wallTime` is zero.
- R10: Writes to the read-only addresses 4, 5, 7 and 8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 4 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Combinational read data at `regAddr` |
| isoStrobe | input | 1 | Commit strobe; its rising edge commits the operation |
| secTick | input | 1 | One-second tick, one cycle wide |
| wallTime | output | 32 | Base plus counter |

## Verification
On every cycle, the assertions check three things. The counter is zero after a clear and holds still when there is no tick. The base and the snapshot change only when their own commands fire. A commit command lasts a single cycle even if the strobe stays high. Only the bench scenarios can show the rest:
- the arithmetic of base plus counter, including the wrap of the sum;
- the order in which read selects are served, and read-after-write within a single commit;
- the two-step counter snapshot;
- the full time-setting sequence seen through the register port.

// File: rtl/rtc_stage_pkg.sv
package rtc_stage_pkg;
  localparam int TIME_W = 32;
  localparam int HALF_W = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_MAIN   = 4'd0;
  localparam logic [ADDR_W-1:0] A_AUX    = 4'd1;
  localparam logic [ADDR_W-1:0] A_STG_LO = 4'd2;
  localparam logic [ADDR_W-1:0] A_STG_HI = 4'd3;
  localparam logic [ADDR_W-1:0] A_RD_LO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_RD_HI  = 4'd5;
  localparam logic [ADDR_W-1:0] A_TRIG   = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd7;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd8;

  localparam int B_WR_BASE = 1;
  localparam int B_RD_BASE = 2;
  localparam int B_CLR_CNT = 3;
  localparam int B_WR_SW0  = 5;
  localparam int B_WR_SW1  = 6;
  localparam int B_RD_SW0  = 7;
  localparam int B_RD_SW1  = 8;

  typedef enum logic [1:0] {RD_NONE, RD_BASE, RD_SW0, RD_SW1} rdSel_e;

  typedef struct packed {
    logic   clrCnt;
    logic   wrBase;
    logic   wrSw0;
    logic   wrSw1;
    rdSel_e rdSel;
    logic   capCnt;
    logic   snap;
  } commitCmd_t;
endpackage

// File: rtl/rtc_stage_ctrl.sv
module rtc_stage_ctrl
  import rtc_stage_pkg::*;
#(
  parameter int TW = TIME_W,
  parameter int HW = HALF_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [HW-1:0] regWrData,
  output logic [HW-1:0] regRdData,
  input  logic          isoStrobe,
  input  logic [TW-1:0] rdWord,
  input  logic [TW-1:0] cntSnap,
  output logic [TW-1:0] stageWord,
  output commitCmd_t    cmd
);
  logic [HW-1:0] mainCtl, auxCtl, stageLo, stageHi;
  logic          strobePrev;
  logic          commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mainCtl    <= '0;
      auxCtl     <= '0;
      stageLo    <= '0;
      stageHi    <= '0;
      strobePrev <= 1'b0;
    end else begin
      strobePrev <= isoStrobe;
      if (regWrEn) begin
        unique case (regAddr)
          A_MAIN:   mainCtl <= regWrData;
          A_AUX:    auxCtl  <= regWrData;
          A_STG_LO: stageLo <= regWrData;
          A_STG_HI: stageHi <= regWrData;
          default:  ;
        endcase
      end
    end
  end

  assign commit    = isoStrobe && !strobePrev;
  assign stageWord = {stageHi, stageLo};

  always_comb begin
    cmd        = '0;
    cmd.rdSel  = RD_NONE;
    cmd.snap   = regWrEn && (regAddr == A_TRIG) && regWrData[0];
    if (commit) begin
      cmd.clrCnt = mainCtl[B_CLR_CNT];
      cmd.wrBase = mainCtl[B_WR_BASE];
      cmd.wrSw0  = mainCtl[B_WR_SW0];
      cmd.wrSw1  = mainCtl[B_WR_SW1];
      cmd.capCnt = auxCtl[0];
      if (mainCtl[B_RD_BASE])     cmd.rdSel = RD_BASE;
      else if (mainCtl[B_RD_SW0]) cmd.rdSel = RD_SW0;
      else if (mainCtl[B_RD_SW1]) cmd.rdSel = RD_SW1;
    end
  end

  always_comb begin
    unique case (regAddr)
      A_MAIN:   regRdData = mainCtl;
      A_AUX:    regRdData = auxCtl;
      A_STG_LO: regRdData = stageLo;
      A_STG_HI: regRdData = stageHi;
      A_RD_LO:  regRdData = rdWord[HW-1:0];
      A_RD_HI:  regRdData = rdWord[TW-1:HW];
      A_CNT_LO: regRdData = cntSnap[HW-1:0];
      A_CNT_HI: regRdData = cntSnap[TW-1:HW];
      default:  regRdData = '0;
    endcase
  end

  // R8: a held strobe yields a single-cycle commit
  p_single_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (isoStrobe && strobePrev) |-> (cmd.rdSel == RD_NONE && !cmd.clrCnt && !cmd.wrBase));
endmodule

// File: rtl/rtc_stage_dp.sv
module rtc_stage_dp
  import rtc_stage_pkg::*;
#(
  parameter int TW = TIME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          secTick,
  input  commitCmd_t    cmd,
  input  logic [TW-1:0] stageWord,
  output logic [TW-1:0] rdWord,
  output logic [TW-1:0] cntSnap,
  output logic [TW-1:0] wallTime
);
  logic [TW-1:0] base, counter, sw0, sw1, cntHold;
  logic [TW-1:0] baseNext, counterNext, sw0Next, sw1Next;

  always_comb begin
    counterNext = counter;
    if (cmd.clrCnt)    counterNext = '0;
    else if (secTick)  counterNext = counter + 1'b1;
    baseNext = cmd.wrBase ? stageWord : base;
    sw0Next  = cmd.wrSw0  ? stageWord : sw0;
    sw1Next  = cmd.wrSw1  ? stageWord : sw1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      counter <= '0;
      sw0     <= '0;
      sw1     <= '0;
      rdWord  <= '0;
      cntHold <= '0;
      cntSnap <= '0;
    end else begin
      base    <= baseNext;
      counter <= counterNext;
      sw0     <= sw0Next;
      sw1     <= sw1Next;
      unique case (cmd.rdSel)
        RD_BASE: rdWord <= baseNext;
        RD_SW0:  rdWord <= sw0Next;
        RD_SW1:  rdWord <= sw1Next;
        default: ;
      endcase
      if (cmd.capCnt) cntHold <= counterNext;
      if (cmd.snap)   cntSnap <= cntHold;
    end
  end

  assign wallTime = base + counter;

  p_clear_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clrCnt |=> (counter == '0));
  p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.clrCnt && !secTick) |=> $stable(counter));
  p_base_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.wrBase |=> $stable(base));
  p_snap_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.snap |=> $stable(cntSnap));
endmodule

// File: rtl/rtc_stage_top.sv
module rtc_stage_top
  import rtc_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [HALF_W-1:0] regWrData,
  output logic [HALF_W-1:0] regRdData,
  input  logic              isoStrobe,
  input  logic              secTick,
  output logic [TIME_W-1:0] wallTime
);
  commitCmd_t        cmd;
  logic [TIME_W-1:0] stageWord, rdWord, cntSnap;

  rtc_stage_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .isoStrobe(isoStrobe),
    .rdWord(rdWord), .cntSnap(cntSnap), .stageWord(stageWord), .cmd(cmd)
  );

  rtc_stage_dp dp_i (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .cmd(cmd),
    .stageWord(stageWord), .rdWord(rdWord), .cntSnap(cntSnap),
    .wallTime(wallTime)
  );
endmodule

// File: tb/rtc_stage_top_tb_top.sv
module rtc_stage_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        isoStrobe = 1'b0;
  logic        secTick = 1'b0;
  logic [31:0] wallTime;
  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  rtc_stage_top dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdData;
  endtask

  task automatic rd32(input logic [3:0] aLo, output logic [31:0] d);
    logic [15:0] lo, hi;
    rd(aLo, lo); rd(aLo + 4'd1, hi); d = {hi, lo};
  endtask

  task automatic strobe();
    @(negedge clk); isoStrobe = 1'b1;
    @(negedge clk); isoStrobe = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
    end
  endtask

  task automatic stage(input logic [31:0] v);
    wr(4'd2, v[15:0]); wr(4'd3, v[31:16]);
  endtask

  task automatic commitMain(input logic [15:0] sel);
    wr(4'd0, sel); strobe(); wr(4'd0, 16'h0000);
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [15:0] h;
    logic [31:0] w;
    logic [31:0] bases [6];
    int cnt;
    bases = '{32'h0000_0000, 32'h0000_0001, 32'h1234_5678, 32'hFFFF_0000, 32'h8000_0001, 32'hDEAD_BEEF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    for (int a = 0; a < 9; a++) begin
      if (a != 6) begin rd(a[3:0], h); chk("R9 reset reg", {16'h0, h}, 32'h0); end
    end
    chk("R9 reset wallTime", wallTime, 32'h0);

    // R2 / R1 counting
    ticks(5); cnt = 5;
    @(negedge clk); chk("R2 count", wallTime, 32'd5);

    // R4 / R6 / R1 base sweep
    foreach (bases[i]) begin
      stage(bases[i]);
      commitMain(16'h0002);
      @(negedge clk); chk("R1 sum", wallTime, bases[i] + cnt);
      commitMain(16'h0004);
      rd32(4'd4, w); chk("R6 read base", w, bases[i]);
      ticks(i); cnt += i;
      @(negedge clk); chk("R2 count after ticks", wallTime, bases[i] + cnt);
    end

    // R4 strobe without select, select without strobe
    stage(32'h0BAD_0BAD);
    strobe();
    @(negedge clk); chk("R4 no select", wallTime, 32'hDEAD_BEEF + cnt);
    wr(4'd0, 16'h0002); stage(32'h0C0C_0C0C);
    repeat (3) @(negedge clk);
    chk("R4 no strobe", wallTime, 32'hDEAD_BEEF + cnt);
    wr(4'd0, 16'h0000);

    // R10 read-only ignore
    wr(4'd4, 16'h5555); wr(4'd5, 16'hAAAA);
    rd32(4'd4, w); chk("R10 rd ro", w, 32'hDEAD_BEEF);
    wr(4'd7, 16'h5555); rd32(4'd7, w); chk("R10 snap ro", w, 32'h0);

    // R3 clear, and clear beats tick
    commitMain(16'h0008); cnt = 0;
    @(negedge clk); chk("R3 clear", wallTime, 32'hDEAD_BEEF);
    ticks(3);
    wr(4'd0, 16'h0008);
    @(negedge clk); isoStrobe = 1'b1; secTick = 1'b1;
    @(negedge clk); isoStrobe = 1'b0; secTick = 1'b0;
    wr(4'd0, 16'h0000);
    chk("R3 clear over tick", wallTime, 32'hDEAD_BEEF);

    // R8 held strobe commits once
    wr(4'd0, 16'h0008);
    @(negedge clk); isoStrobe = 1'b1;
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); @(negedge clk); secTick = 1'b0;
    @(negedge clk); isoStrobe = 1'b0;
    wr(4'd0, 16'h0000);
    chk("R8 held strobe", wallTime, 32'hDEAD_BEEF + 2);
    commitMain(16'h0008);

    // R5 / R6 software words and read priority
    stage(32'h1111_2222); commitMain(16'h0020);
    stage(32'h3333_4444); commitMain(16'h0040);
    commitMain(16'h0080); rd32(4'd4, w); chk("R5 sw0", w, 32'h1111_2222);
    commitMain(16'h0100); rd32(4'd4, w); chk("R5 sw1", w, 32'h3333_4444);
    commitMain(16'h0180); rd32(4'd4, w); chk("R6 prio sw0 over sw1", w, 32'h1111_2222);
    commitMain(16'h0184); rd32(4'd4, w); chk("R6 prio base first", w, 32'hDEAD_BEEF);
    stage(32'h7777_8888); commitMain(16'h00A0);
    rd32(4'd4, w); chk("R6 read after write", w, 32'h7777_8888);

    // R7 counter snapshot
    ticks(7);
    wr(4'd1, 16'h0001); strobe(); wr(4'd1, 16'h0000);
    ticks(4);
    rd32(4'd7, w); chk("R7 before trigger", w, 32'h0);
    wr(4'd6, 16'h0001);
    rd32(4'd7, w); chk("R7 snapshot", w, 32'd7);
    ticks(2); wr(4'd6, 16'h0000);
    rd32(4'd7, w); chk("R7 stable", w, 32'd7);
    chk("R1 live", wallTime, 32'hDEAD_BEEF + 13);

    // R1 wrap of the sum
    stage(32'hFFFF_FFF0); commitMain(16'h000A);
    ticks(20);
    @(negedge clk); chk("R1 wrap", wallTime, 32'd4);

    // R5 time-set sequence
    stage(32'h6500_0000); commitMain(16'h0002);
    commitMain(16'h0008);
    stage(32'h0000_0001); commitMain(16'h0020);
    commitMain(16'h0080); rd32(4'd4, w); chk("R5 valid flag", w, 32'h1);
    chk("R5 time set", wallTime, 32'h6500_0000);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule